// File: doc/BRIEF.md
# Tick Match Timer with Watchdog Channel

This block keeps a free-running 32-bit tick count and compares it with four match registers. The count advances once for every cycle in which the tick-enable input is high. When a tick moves the count onto a match value, that channel raises a sticky status flag, provided its interrupt enable is set. The flags drive the interrupt request outputs towards an external interrupt controller. Software acknowledges a flag by writing a one to its status bit.

The last channel can guard the system. Once software sets the write-once watchdog enable, a match on that channel raises a one-cycle reset request and no interrupt. Software cannot clear the enable. A hardware reset, a software reset, a sleep reset, or the watchdog's own firing clears it.

The watchdog enable is held in a three-state machine:

- `WD_OFF`: the channel behaves as an interrupt source. A write of one to bit 0 of the enable register moves the machine to `WD_ARMED`.
- `WD_ARMED`: a tick that lands on the channel's match value moves the machine to `WD_BITE`. Writes to the enable register leave it in `WD_ARMED`.
- `WD_BITE`: lasts one cycle, drives the reset request, and always returns to `WD_OFF`.

Asserting soft_rst or sleep_rst moves the machine from any state to `WD_OFF`.

The bus uses word addresses:

| Address | Register |
|---|---|
| 0 to 3 | Match registers for channels 0 to 3 |
| 4 | Counter |
| 5 | Status |
| 6 | Interrupt enable |
| 7 | Watchdog enable |

Top module: `tick_match_timer`

## Requirements
- R1: After rst_n is deasserted, every bus address (0 to 7) reads zero, and irq and rst_req are low.
- R2: The counter at address 4 rises by exactly one at each clock edge where tick_en is high. It holds its value when tick_en is low, and it wraps from 0xFFFFFFFF to 0 with no flag.
- R3: A bus write to address 4 loads the counter, and this load wins over a tick in the same cycle.
- R4: The match registers at addresses 0 to 3 store and return all 32 bits written to them.
- R5: Status bit i at address 5 is set at the edge where a tick moves the counter onto match register i. This happens only if bit i of the interrupt enable at address 6 is one. irq[i] equals status bit i.
- R6: Status bits are sticky. Writing one to a status bit clears it, and writing zero leaves it unchanged. A set in the same cycle as a clear wins.
- R7: The interrupt enable keeps only bits 3:0, and the watchdog enable keeps only bit 0. All other bits of both registers read zero.
- R8: Writing one to watchdog-enable bit 0 sets it. Writing zero to it has no effect.
- R9: While the watchdog enable is set, a tick onto match register 3 has three effects. rst_req goes high for exactly one cycle, starting at that edge. Status bit 3 is not set. The watchdog enable reads zero afterwards.
- R10: A cycle with soft_rst or sleep_rst high returns every register to its reset value, including the watchdog enable.
- R11: Matches are checked only on ticks. Loading the counter with a match value by a bus write sets no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| soft_rst | input | 1 | Synchronous software reset |
| sleep_rst | input | 1 | Synchronous sleep-entry reset |
| tick_en | input | 1 | Timer tick strobe, one count per high cycle |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 4 | Per-channel interrupt requests (the status bits) |
| rst_req | output | 1 | One-cycle system reset request from the watchdog |

## Verification
A wrong count or a lost tick appears at the next read of address 4. It also moves every later match event, which then appears on irq one tick early or late. A corrupted watchdog state shows either as a reset request where an interrupt was expected, or as an enable bit that reads wrongly. These errors are visible in the cycle right after the matching tick. The benches therefore sample irq and rst_req one edge after each tick and sweep all sixteen interrupt-enable patterns.

// File: rtl/tmt_pkg.sv
package tmt_pkg;
    localparam int TMT_CNT_W = 32;
    localparam int TMT_N_CH  = 4;

    typedef enum logic [1:0] {
        WD_OFF   = 2'd0,
        WD_ARMED = 2'd1,
        WD_BITE  = 2'd2
    } wd_state_t;
endpackage

// File: rtl/tmt_counter.sv
module tmt_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cnt_next,
    output logic         cmp_stb
);
    assign cnt_next = cnt + W'(1);
    // Compare only on a tick that actually advanced the count.
    assign cmp_stb  = tick & ~load & ~clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt <= '0;
        else if (clr)    cnt <= '0;
        else if (load)   cnt <= load_val;
        else if (tick)   cnt <= cnt_next;
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && !clr) |=> cnt == $past(cnt) + W'(1)); // R2
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load && !clr) |=> $stable(cnt)); // R2
    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clr) |=> cnt == $past(load_val)); // R3
endmodule

// File: rtl/tmt_match_chan.sv
module tmt_match_chan #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         mr_we,
    input  logic [W-1:0] wdata,
    input  logic         st_w1c,
    input  logic         cmp_stb,
    input  logic [W-1:0] cnt_next,
    input  logic         ie,
    input  logic         to_irq,
    output logic [W-1:0] match_val,
    output logic         status
);
    logic hit;
    logic set_st;

    assign hit    = cmp_stb && (cnt_next == match_val);
    assign set_st = hit && ie && to_irq;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      match_val <= '0;
        else if (clr)    match_val <= '0;
        else if (mr_we)  match_val <= wdata;
    end

    // Set takes priority over a same-cycle write-one-to-clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       status <= 1'b0;
        else if (clr)     status <= 1'b0;
        else if (set_st)  status <= 1'b1;
        else if (st_w1c)  status <= 1'b0;
    end

    AST_ST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status && !st_w1c && !clr) |=> status); // R6
    AST_ST_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_stb && cnt_next == match_val && ie && to_irq && !clr) |=> status); // R5
    AST_ST_TICK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!status && !cmp_stb) |=> !status); // R11
endmodule

// File: rtl/tmt_wdog.sv
module tmt_wdog
    import tmt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic arm_we,
    input  logic ch_hit,
    output logic armed,
    output logic rst_req
);
    wd_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WD_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (clr) begin
            state_d = WD_OFF;
        end else begin
            unique case (state_q)
                WD_OFF:   if (arm_we) state_d = WD_ARMED;
                WD_ARMED: if (ch_hit) state_d = WD_BITE;
                WD_BITE:  state_d = WD_OFF;
                default:  state_d = WD_OFF;
            endcase
        end
    end

    always_comb begin
        armed   = 1'b0;
        rst_req = 1'b0;
        unique case (state_q)
            WD_OFF:   ;
            WD_ARMED: armed   = 1'b1;
            WD_BITE:  rst_req = 1'b1;
            default:  ;
        endcase
    end

    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req); // R9
    AST_WDE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !ch_hit && !clr) |=> armed); // R8
    AST_BITE: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && ch_hit && !clr) |=> (rst_req && !armed)); // R9
    AST_CLR_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!armed && !rst_req)); // R10
endmodule

// File: rtl/tick_match_timer.sv
module tick_match_timer
    import tmt_pkg::*;
#(
    parameter int CNT_W = TMT_CNT_W,
    parameter int N_CH  = TMT_N_CH,
    localparam int ADDR_W = $clog2(N_CH + 4)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              sleep_rst,
    input  logic              tick_en,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic [N_CH-1:0]   irq,
    output logic              rst_req
);
    localparam int WD_CH = N_CH - 1;
    localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(N_CH);
    localparam logic [ADDR_W-1:0] A_ST  = ADDR_W'(N_CH + 1);
    localparam logic [ADDR_W-1:0] A_IE  = ADDR_W'(N_CH + 2);
    localparam logic [ADDR_W-1:0] A_WD  = ADDR_W'(N_CH + 3);

    logic             clr;
    logic             wr;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_next;
    logic             cmp_stb;
    logic [N_CH-1:0]  ie_q;
    logic [N_CH-1:0]  status;
    logic [CNT_W-1:0] mval [N_CH];
    logic             wd_armed;
    logic             wd_hit;

    assign clr = soft_rst | sleep_rst;
    assign wr  = bus_sel & bus_wr;

    tmt_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .tick     (tick_en),
        .load     (wr && bus_addr == A_CNT),
        .load_val (bus_wdata),
        .cnt      (cnt),
        .cnt_next (cnt_next),
        .cmp_stb  (cmp_stb)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        logic route_irq;
        if (g == WD_CH) begin : g_wd
            assign route_irq = ~wd_armed;
        end else begin : g_plain
            assign route_irq = 1'b1;
        end
        tmt_match_chan #(.W(CNT_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (clr),
            .mr_we     (wr && bus_addr == ADDR_W'(g)),
            .wdata     (bus_wdata),
            .st_w1c    (wr && bus_addr == A_ST && bus_wdata[g]),
            .cmp_stb   (cmp_stb),
            .cnt_next  (cnt_next),
            .ie        (ie_q[g]),
            .to_irq    (route_irq),
            .match_val (mval[g]),
            .status    (status[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        ie_q <= '0;
        else if (clr)                      ie_q <= '0;
        else if (wr && bus_addr == A_IE)   ie_q <= bus_wdata[N_CH-1:0];
    end

    assign wd_hit = cmp_stb && (cnt_next == mval[WD_CH]);

    tmt_wdog u_wd (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .arm_we  (wr && bus_addr == A_WD && bus_wdata[0]),
        .ch_hit  (wd_hit),
        .armed   (wd_armed),
        .rst_req (rst_req)
    );

    assign irq = status;

    always_comb begin
        bus_rdata = '0;
        for (int k = 0; k < N_CH; k++) begin
            if (bus_addr == ADDR_W'(k)) bus_rdata = mval[k];
        end
        if (bus_addr == A_CNT) bus_rdata = cnt;
        if (bus_addr == A_ST)  bus_rdata = {{(CNT_W-N_CH){1'b0}}, status};
        if (bus_addr == A_IE)  bus_rdata = {{(CNT_W-N_CH){1'b0}}, ie_q};
        if (bus_addr == A_WD)  bus_rdata = {{(CNT_W-1){1'b0}}, wd_armed};
    end

    AST_WD_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_armed && wd_hit && !irq[WD_CH]) |=> !irq[WD_CH]); // R9
    AST_RST_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> $past(wd_armed)); // R9
    AST_SYNC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (irq == '0 && !rst_req)); // R10
endmodule

// File: tb/tick_match_timer_test.sv
module tick_match_timer_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        sleep_rst = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq;
    logic        rst_req;

    int n_chk = 0;
    int n_fail = 0;

    tick_match_timer uut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .sleep_rst(sleep_rst),
        .tick_en(tick_en), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .rst_req(rst_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bwrite(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bwrite_tick(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tick_en = 1'b1;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0; tick_en = 1'b0;
    endtask

    task automatic bread(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic do_tick();
        @(negedge clk);
        tick_en = 1'b1;
        @(posedge clk); #1;
        tick_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [2:0] a, input logic [31:0] exp);
        logic [31:0] v;
        bread(a, v);
        check(req, v, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL timeout actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [3:0] exp_st;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 8; a++) rd_check("R1 reg", 3'(a), 32'h0);
        check("R1 irq", {28'h0, irq}, 32'h0);
        check("R1 rst_req", {31'h0, rst_req}, 32'h0);

        // R4: match registers hold full width
        for (int i = 0; i < 4; i++) bwrite(3'(i), 32'hA5C3_0F00 ^ (32'h1111_1111 * i));
        for (int i = 0; i < 4; i++) rd_check("R4 match", 3'(i), 32'hA5C3_0F00 ^ (32'h1111_1111 * i));

        // R2: increment, hold, wrap
        bwrite(3'd4, 32'd100);
        for (int i = 0; i < 5; i++) do_tick();
        rd_check("R2 count", 3'd4, 32'd105);
        repeat (3) @(posedge clk);
        rd_check("R2 hold", 3'd4, 32'd105);
        bwrite(3'd4, 32'hFFFF_FFFE);
        for (int i = 0; i < 3; i++) do_tick();
        rd_check("R2 wrap", 3'd4, 32'd1);

        // R3: load wins over coincident tick
        bwrite_tick(3'd4, 32'h1234_5678);
        rd_check("R3 load", 3'd4, 32'h1234_5678);

        // R5: sweep all enable patterns over four consecutive matches
        for (int i = 0; i < 4; i++) bwrite(3'(i), 32'd200 + 32'(i));
        for (int ie = 0; ie < 16; ie++) begin
            bwrite(3'd5, 32'hF);
            bwrite(3'd6, 32'(ie));
            bwrite(3'd4, 32'd199);
            exp_st = 4'h0;
            for (int k = 0; k < 4; k++) begin
                do_tick();
                if (ie[k]) exp_st[k] = 1'b1;
                check("R5 irq", {28'h0, irq}, {28'h0, exp_st});
                rd_check("R5 status", 3'd5, {28'h0, exp_st});
            end
        end

        // R11: bus load onto a match value does not match
        bwrite(3'd5, 32'hF);
        bwrite(3'd6, 32'hF);
        bwrite(3'd4, 32'd200);
        bwrite(3'd4, 32'd201);
        rd_check("R11 no match on load", 3'd5, 32'h0);

        // R6: sticky, W1C, set wins
        bwrite(3'd6, 32'h1);
        bwrite(3'd4, 32'd199);
        bwrite_tick(3'd5, 32'h1);
        rd_check("R6 set wins", 3'd5, 32'h1);
        bwrite(3'd5, 32'h0);
        rd_check("R6 write zero", 3'd5, 32'h1);
        bwrite(3'd5, 32'h1);
        rd_check("R6 w1c", 3'd5, 32'h0);

        // R7 and R8: reserved bits and write-once enable
        bwrite(3'd6, 32'hFFFF_FFFF);
        rd_check("R7 ie width", 3'd6, 32'hF);
        bwrite(3'd7, 32'hFFFF_FFFE);
        rd_check("R7 wde reserved", 3'd7, 32'h0);
        bwrite(3'd7, 32'hFFFF_FFFF);
        rd_check("R7 wde upper zero", 3'd7, 32'h1);
        bwrite(3'd7, 32'h0);
        rd_check("R8 write zero keeps", 3'd7, 32'h1);

        // R9: watchdog bite
        bwrite(3'd5, 32'hF);
        bwrite(3'd3, 32'd500);
        bwrite(3'd4, 32'd498);
        do_tick();
        check("R9 no early req", {31'h0, rst_req}, 32'h0);
        do_tick();
        check("R9 req pulse", {31'h0, rst_req}, 32'h1);
        check("R9 no irq3", {31'h0, irq[3]}, 32'h0);
        @(posedge clk); #1;
        check("R9 pulse width", {31'h0, rst_req}, 32'h0);
        rd_check("R9 wde cleared", 3'd7, 32'h0);
        rd_check("R9 status3 clear", 3'd5, 32'h0);
        bwrite(3'd4, 32'd499);
        do_tick();
        check("R9 irq mode", {31'h0, irq[3]}, 32'h1);
        check("R9 irq mode no req", {31'h0, rst_req}, 32'h0);

        // R10: software and sleep reset
        bwrite(3'd7, 32'h1);
        bwrite(3'd4, 32'd77);
        @(negedge clk); soft_rst = 1'b1;
        @(posedge clk); #1 soft_rst = 1'b0;
        for (int a = 0; a < 8; a++) rd_check("R10 soft", 3'(a), 32'h0);
        check("R10 irq", {28'h0, irq}, 32'h0);
        bwrite(3'd7, 32'h1);
        bwrite(3'd6, 32'h3);
        @(negedge clk); sleep_rst = 1'b1;
        @(posedge clk); #1 sleep_rst = 1'b0;
        rd_check("R10 sleep wde", 3'd7, 32'h0);
        rd_check("R10 sleep ie", 3'd6, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule